// File: doc/BRIEF.md
# Recursive Karatsuba Unsigned Multiplier

This block multiplies two unsigned operands and delivers the full-width product. It never uses a wide array multiplier. Each operand is cut into a low part and a high part. Only three products of about half the width are formed: low by low, high by high, and the sum of the parts by the sum of the parts. The cross term is the third product minus the first two. The full product is then rebuilt from shifted additions.

The same node is applied to each of the three sub-products, three levels deep. The leaves are small direct multipliers. In the default 24-bit form, the widths go 24, 12, 6, 3. A sum of two halves is one bit wider than a half, so the middle branch at each level is one bit wider than its siblings, and the leaves take 3 to 5 bits.

A parameter selects a wide form with 53-bit operands. These are zero-padded to 56 bits and halved down to 7-bit leaves. A second parameter places a register after every recursion level. The valid flag travels beside the data with the same latency.

Top module: `kara_mul`

## Requirements
- R1: In the default form, `p_o` equals the exact 48-bit unsigned product `a_i * b_i` for any pair of 24-bit operands.
- R2: While `rst_n` is low and until the first operands reach the output, `valid_o` is 0. With pipelining on, `p_o` is 0 during that time.
- R3: With `PIPE=1`, each operand pair shows up at `p_o` exactly three clock cycles after it is presented. With `PIPE=0`, the product path is purely combinational.
- R4: At every node, the sum-by-sum product is at least the sum of the low-by-low and high-by-high products. The middle term therefore never wraps below zero.
- R5: With `WIDE=1`, operands are 53 bits and are zero-extended to 56 bits inside the block. `p_o` is the exact 106-bit product, and the padded product's top six bits are 0.
- R6: `valid_o` repeats `valid_i` delayed by the same latency as the product. The data path moves every cycle whatever the state of `valid_i`.
- R7: The corner operands 0, 1 and all ones (0xFFFFFF; in the wide form, 2^53-1) give 0, the other operand, and the largest product respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair qualifier |
| a_i | input | 24 (53 when WIDE=1) | Unsigned operand A |
| b_i | input | 24 (53 when WIDE=1) | Unsigned operand B |
| valid_o | output | 1 | Product qualifier, delayed copy of valid_i |
| p_o | output | 48 (106 when WIDE=1) | Unsigned product |

## Verification
Directed pairs with one operand 0 or 1 show whether any stray term leaks into the rebuild. Squares of all ones drive every middle sum to its carry bit and load the subtraction at its largest value. Single-bit powers of two probe each split boundary on its own. Random pairs sent with a random valid pattern show that data and valid stay aligned at the pipeline depth. A second, combinational, wide instance is fed its own corners and random values, which checks the padded 56-bit tree.

// File: rtl/kara_node.sv
module kara_node #(
  parameter int W    = 24,
  parameter int LVL  = 3,
  parameter bit PIPE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int H  = W / 2;
  localparam int HW = W - H;
  localparam int MW = HW + 1;
  localparam int PW = 2 * W;

  generate
    if (LVL == 0) begin : g_leaf
      assign p = PW'(x) * PW'(y);

      a_r1_leaf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (x == '0 || y == '0) |-> (p == '0));
    end else begin : g_split
      logic [MW-1:0]   xs, ys;
      logic [2*H-1:0]  pl;
      logic [2*HW-1:0] ph;
      logic [2*MW-1:0] pm;
      logic [PW-1:0]   mid, sum;

      assign xs = MW'(x[H-1:0]) + MW'(x[W-1:H]);
      assign ys = MW'(y[H-1:0]) + MW'(y[W-1:H]);

      kara_node #(.W(H),  .LVL(LVL-1), .PIPE(PIPE)) u_lo (
        .clk(clk), .rst_n(rst_n), .x(x[H-1:0]), .y(y[H-1:0]), .p(pl));
      kara_node #(.W(HW), .LVL(LVL-1), .PIPE(PIPE)) u_hi (
        .clk(clk), .rst_n(rst_n), .x(x[W-1:H]), .y(y[W-1:H]), .p(ph));
      kara_node #(.W(MW), .LVL(LVL-1), .PIPE(PIPE)) u_md (
        .clk(clk), .rst_n(rst_n), .x(xs), .y(ys), .p(pm));

      assign mid = PW'(pm) - PW'(pl) - PW'(ph);
      assign sum = (PW'(ph) << (2*H)) + (mid << H) + PW'(pl);

      a_r4_mid_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        ((PW+2)'(pm) >= (PW+2)'(pl) + (PW+2)'(ph)));

      if (PIPE) begin : g_reg
        logic [PW-1:0] p_q;
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) p_q <= '0;
          else        p_q <= sum;
        assign p = p_q;
      end else begin : g_comb
        assign p = sum;
      end
    end
  endgenerate
endmodule

// File: rtl/kara_mul.sv
module kara_mul #(
  parameter bit WIDE = 1'b0,
  parameter bit PIPE = 1'b1,
  parameter int LVLS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            valid_i,
  input  logic [(WIDE ? 53 : 24)-1:0]     a_i,
  input  logic [(WIDE ? 53 : 24)-1:0]     b_i,
  output logic                            valid_o,
  output logic [2*(WIDE ? 53 : 24)-1:0]   p_o
);
  localparam int IW  = WIDE ? 53 : 24;
  localparam int PW  = WIDE ? 56 : 24;
  localparam int LAT = PIPE ? LVLS : 0;

  logic [2*PW-1:0] pp;
  logic [2:0]      warm;

  kara_node #(.W(PW), .LVL(LVLS), .PIPE(PIPE)) u_root (
    .clk(clk), .rst_n(rst_n), .x(PW'(a_i)), .y(PW'(b_i)), .p(pp));

  assign p_o = pp[2*IW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                warm <= '0;
    else if (32'(warm) < LAT)  warm <= warm + 3'd1;

  generate
    if (LAT == 0) begin : g_nv
      assign valid_o = valid_i;

      a_r1_comb_product: assert property (@(posedge clk) disable iff (!rst_n)
        p_o == ((2*IW)'(a_i) * (2*IW)'(b_i)));
    end else begin : g_vd
      logic [LAT-1:0] vs;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) vs <= '0;
        else        vs <= (vs << 1) | LAT'(valid_i);
      assign valid_o = vs[LAT-1];

      a_r3_product_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(warm) >= LAT) |-> (p_o == $past((2*IW)'(a_i) * (2*IW)'(b_i), LAT)));
      a_r6_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(warm) >= LAT) |-> (valid_o == $past(valid_i, LAT)));
      a_r2_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(warm) < LAT) |-> (!valid_o && p_o == '0));
    end

    if (PW > IW) begin : g_pad
      a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pp[2*PW-1:2*IW] == '0);
    end
  endgenerate
endmodule

// File: tb/sim_kara_mul.sv
module sim_kara_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [23:0] a_i = '0, b_i = '0;
  logic valid_o;
  logic [47:0] p_o;

  logic        wv_i = 1'b0;
  logic [52:0] wa_i = '0, wb_i = '0;
  logic        wv_o;
  logic [105:0] wp_o;

  int n_tests = 0;
  int n_fail  = 0;
  int filled  = 0;
  logic [23:0] ha [0:2];
  logic [23:0] hb [0:2];
  logic        hv [0:2];

  always #5 clk = ~clk;

  kara_mul #(.WIDE(1'b0), .PIPE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .p_o(p_o));

  kara_mul #(.WIDE(1'b1), .PIPE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .valid_i(wv_i), .a_i(wa_i), .b_i(wb_i),
    .valid_o(wv_o), .p_o(wp_o));

  function automatic logic [47:0] ref24(input logic [23:0] a, input logic [23:0] b);
    return 48'(a) * 48'(b);
  endfunction

  function automatic logic [105:0] ref53(input logic [52:0] a, input logic [52:0] b);
    return 106'(a) * 106'(b);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] na, input logic [23:0] nb, input logic nv, input string rq);
    @(negedge clk);
    if (filled >= 3) begin
      chk(p_o == ref24(ha[2], hb[2]), rq, 128'(p_o), 128'(ref24(ha[2], hb[2])));
      chk(valid_o == hv[2], "R3 R6 valid", 128'(valid_o), 128'(hv[2]));
    end
    for (int i = 2; i > 0; i--) begin
      ha[i] = ha[i-1]; hb[i] = hb[i-1]; hv[i] = hv[i-1];
    end
    ha[0] = na; hb[0] = nb; hv[0] = nv;
    a_i = na; b_i = nb; valid_i = nv;
    filled++;
  endtask

  task automatic wide(input logic [52:0] na, input logic [52:0] nb, input string rq);
    wa_i = na; wb_i = nb; wv_i = 1'b1;
    #1;
    chk(wp_o == ref53(na, nb), rq, 128'(wp_o), 128'(ref53(na, nb)));
    chk(wv_o == 1'b1, "R5 wide valid", 128'(wv_o), 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R2: quiet state during reset
    chk(valid_o == 1'b0, "R2 valid in reset", 128'(valid_o), 128'd0);
    chk(p_o == '0, "R2 product in reset", 128'(p_o), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 valid after reset", 128'(valid_o), 128'd0);

    // R7 corners, R4 all-ones maximises the middle sums
    step(24'd0,       24'hABCDEF, 1'b1, "R7 zero a");
    step(24'h123456,  24'd0,      1'b1, "R7 zero b");
    step(24'd1,       24'h9A5C3E, 1'b1, "R7 one a");
    step(24'h7F00FF,  24'd1,      1'b1, "R7 one b");
    step(24'hFFFFFF,  24'hFFFFFF, 1'b1, "R4 R7 all ones");
    step(24'hFFFFFF,  24'd1,      1'b0, "R7 ones by one");
    step(24'd1,       24'd1,      1'b1, "R7 one by one");
    // R1 single bits across split points
    for (int k = 0; k < 24; k++)
      step(24'(1) << k, 24'(1) << (23 - k), 1'b1, "R1 power of two");
    step(24'hFFF000, 24'h000FFF, 1'b0, "R4 halves");
    step(24'hE38E38, 24'h1C71C7, 1'b1, "R4 thirds");
    // R1 R6 random data and valid
    for (int k = 0; k < 300; k++)
      step(24'($urandom), 24'($urandom), 1'($urandom), "R1 random");
    // R3 single valid pulse then drain
    step(24'h000000, 24'h000000, 1'b0, "R3 idle");
    step(24'h00BEEF, 24'h00CAFE, 1'b1, "R3 pulse");
    for (int k = 0; k < 4; k++)
      step(24'd0, 24'd0, 1'b0, "R3 drain");

    // R5 wide combinational variant
    wide(53'd0, {53{1'b1}}, "R5 R7 wide zero");
    wide(53'd1, 53'h1F_0123_4567_89AB, "R5 R7 wide one");
    wide({53{1'b1}}, {53{1'b1}}, "R5 R4 wide all ones");
    wide(53'(1) << 52, 53'(1) << 52, "R5 wide top bit");
    for (int k = 0; k < 200; k++)
      wide({21'($urandom), 32'($urandom)}, {21'($urandom), 32'($urandom)}, "R5 wide random");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule